// File: doc/BRIEF.md
# SDRAM Command Sequence Checker

This block sits beside the command pins of a four-bank synchronous DRAM and watches them each clock. It registers the clock-enable pin to obtain the previous-cycle value, decodes the chip-select, row strobe, column strobe and write-enable lines into a command, and keeps a model of every bank: whether it is idle or open, and whether it is locked by a running burst that ends in an automatic close. It also tracks the device's power mode: normal, power down, self refresh, deep power down, or waiting for re-initialisation.

Any command that breaks the sequencing rules raises a registered one-cycle error pulse with a code that says which rule was broken. An illegal command is not applied to the bank or mode model. The block also drives the two data-mask enables. The write mask follows the mask pin with no delay. The read output-disable follows it two clocks later.

The timing of the memory array, the data path and the analog behaviour are not modelled.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With cs_n low, {ras_n,cas_n,we_n} decodes as 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop and 111 NOP. With cs_n high the cycle is a deselect. A legal activate sets bank_open[bs], where bs value 0..3 selects bit 0..3.
- R2: Activating a bank that is already open gives err_code 1 and leaves bank_open unchanged.
- R3: A read or write to an idle bank gives err_code 2.
- R4: A precharge with a10 high closes every bank, whatever the value of bs. With a10 low it closes only bank bs.
- R5: A mode set while any bank is open gives err_code 3. A legal mode set with bs[1]=0 is a base mode set and loads a burst length of 1<<bl_sel (1, 2, 4 or 8). With bs[1]=1 it is an extended mode set and leaves the burst length unchanged.
- R6: In the two cycles after an accepted mode set, any command other than NOP or deselect gives err_code 5 and is not applied.
- R7: A refresh gives err_code 4 while any bank is open. This applies both as an auto refresh with cke high in both cycles and as a self-refresh entry (cke high the cycle before, low now). A legal self-refresh entry sets dev_mode 2. Raising cke again returns dev_mode to 0.
- R8: A legal read or write with a10 high locks its bank for the burst length in cycles. During the lock, a read or write to that bank gives err_code 6, while other banks stay usable. The bank closes by itself on the last lock cycle.
- R9: wr_mask equals dqm in the same cycle.
- R10: rd_hiz equals the dqm value sampled two rising edges earlier.
- R11: A burst-stop encoding on a falling cke enters deep power down. This sets dev_mode 3 and closes all banks. A rising cke from there gives dev_mode 4.
- R12: In dev_mode 4, activate, read, write and burst stop give err_code 7. A legal base mode set returns dev_mode to 0. Code 7 takes priority over code 5, which takes priority over the other codes.
- R13: err is high for exactly the cycle after the edge that sampled an illegal command, with err_code holding its code; both are 0 otherwise. A falling cke with any command other than refresh or burst stop, in dev_mode 0, enters power down (dev_mode 1), and a rising cke leaves it. After reset, dev_mode, bank_open, err and err_code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cke | input | 1 | Clock-enable pin of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bs | input | 2 | Bank select |
| a10 | input | 1 | All-bank / auto-close address bit |
| bl_sel | input | 2 | Burst-length field of the mode operand |
| dqm | input | 1 | Data mask pin |
| wr_mask | output | 1 | Write data mask, zero latency |
| rd_hiz | output | 1 | Read output disable, two-cycle latency |
| err | output | 1 | Rule violation pulse |
| err_code | output | 4 | Violated rule code |
| bank_open | output | 4 | Open state of each bank |
| dev_mode | output | 3 | Device power / init mode |

## Verification
Directed sequences cover each rule on its own: a repeated activate, an access to an idle bank, single-bank versus all-bank close, a mode set followed at once by a command, an auto-closing burst probed inside its lock and just after it ends, refresh with an open bank, and the full deep power down, wake and re-init path. These separate the error codes from one another and show that an errored command leaves the state untouched. Seeded random command streams then mix power-mode changes with bank traffic. A bench reference model predicts the code, bank vector, mode and both masks every cycle, so wrong priorities and off-by-one lock or latency counts show up as mismatches.

// File: rtl/sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sdram_cmd_monitor #(
  parameter int BS_W    = 2,
  parameter int MRS_GAP = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BS_W-1:0]        bs,
  input  logic                   a10,
  input  logic [1:0]             bl_sel,
  input  logic                   dqm,
  output logic                   wr_mask,
  output logic                   rd_hiz,
  output logic                   err,
  output logic [3:0]             err_code,
  output logic [(1<<BS_W)-1:0]   bank_open,
  output logic [2:0]             dev_mode
);
  localparam int NB = 1 << BS_W;
  localparam int GW = $clog2(MRS_GAP + 1);

  localparam logic [2:0] C_MRS = 3'd0, C_REF = 3'd1, C_PRE = 3'd2, C_ACT = 3'd3,
                         C_WR  = 3'd4, C_RD  = 3'd5, C_BST = 3'd6, C_NOP = 3'd7;

  localparam logic [3:0] E_NONE = 4'd0, E_REOPEN = 4'd1, E_IDLE = 4'd2, E_MRS = 4'd3,
                         E_REF  = 4'd4, E_GAP    = 4'd5, E_LOCK = 4'd6, E_INIT = 4'd7;

  typedef enum logic [2:0] {
    M_NORM = 3'd0, M_PD = 3'd1, M_SR = 3'd2, M_DPD = 3'd3, M_INIT = 3'd4
  } mode_t;

  mode_t          mode_q;
  logic           cke_q;
  logic [NB-1:0]  open_q;
  logic [3:0]     lock_q [NB];
  logic [3:0]     bl_q;
  logic [GW-1:0]  gap_q;
  logic           dqm_d1, dqm_d2;
  logic [3:0]     code;
  logic [3:0]     code_q;
  logic           err_q;

  wire [2:0] cmd  = {ras_n, cas_n, we_n};
  wire live  = cke_q & cke;
  wire enter = cke_q & ~cke;
  wire leave = ~cke_q & cke;
  wire run   = live & (mode_q == M_NORM || mode_q == M_INIT);

  wire is_nop = cs_n | (cmd == C_NOP);
  wire is_mrs = ~cs_n & (cmd == C_MRS);
  wire is_ref = ~cs_n & (cmd == C_REF);
  wire is_pre = ~cs_n & (cmd == C_PRE);
  wire is_act = ~cs_n & (cmd == C_ACT);
  wire is_rw  = ~cs_n & (cmd == C_WR || cmd == C_RD);
  wire is_bst = ~cs_n & (cmd == C_BST);

  wire any_open = |open_q;
  wire sel_open = open_q[bs];
  wire sel_lock = lock_q[bs] != 4'd0;

  always_comb begin
    code = E_NONE;
    if (run) begin
      if (mode_q == M_INIT && (is_act | is_rw | is_bst)) code = E_INIT;
      else if (gap_q != '0 && !is_nop)                     code = E_GAP;
      else if (is_act && sel_open)                         code = E_REOPEN;
      else if (is_rw && !sel_open)                         code = E_IDLE;
      else if (is_rw && sel_lock)                          code = E_LOCK;
      else if (is_mrs && any_open)                         code = E_MRS;
      else if (is_ref && any_open)                         code = E_REF;
    end else if (enter && mode_q == M_NORM && is_ref && any_open) begin
      code = E_REF;
    end
  end

  wire go       = run & (code == E_NONE);
  wire dpd_in   = enter & (mode_q == M_NORM) & is_bst;
  wire base_mrs = go & is_mrs & ~bs[BS_W-1];

  for (genvar i = 0; i < NB; i++) begin : g_bank
    wire hit = (bs == BS_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[i] <= 1'b0;
        lock_q[i] <= 4'd0;
      end else if (dpd_in || (go && is_pre && (a10 || hit))) begin
        open_q[i] <= 1'b0;
        lock_q[i] <= 4'd0;
      end else if (go && is_act && hit) begin
        open_q[i] <= 1'b1;
      end else if (go && is_rw && a10 && hit) begin
        lock_q[i] <= bl_q;
      end else if (lock_q[i] == 4'd1) begin
        open_q[i] <= 1'b0;
        lock_q[i] <= 4'd0;
      end else if (lock_q[i] != 4'd0) begin
        lock_q[i] <= lock_q[i] - 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b1;
      bl_q   <= 4'd1;
      gap_q  <= '0;
      mode_q <= M_NORM;
      err_q  <= 1'b0;
      code_q <= E_NONE;
      dqm_d1 <= 1'b0;
      dqm_d2 <= 1'b0;
    end else begin
      cke_q  <= cke;
      err_q  <= code != E_NONE;
      code_q <= code;
      dqm_d1 <= dqm;
      dqm_d2 <= dqm_d1;
      if (go && is_mrs)     gap_q <= GW'(MRS_GAP);
      else if (gap_q != '0) gap_q <= gap_q - 1'b1;
      if (base_mrs) bl_q <= 4'd1 << bl_sel;
      unique case (mode_q)
        M_NORM: if (enter) begin
          if (is_ref)      mode_q <= any_open ? M_NORM : M_SR;
          else if (is_bst) mode_q <= M_DPD;
          else             mode_q <= M_PD;
        end
        M_PD, M_SR: if (leave) mode_q <= M_NORM;
        M_DPD:      if (leave) mode_q <= M_INIT;
        M_INIT:     if (base_mrs) mode_q <= M_NORM;
        default:    mode_q <= M_NORM;
      endcase
    end
  end

  assign wr_mask   = dqm;
  assign rd_hiz    = dqm_d2;
  assign err       = err_q;
  assign err_code  = code_q;
  assign bank_open = open_q;
  assign dev_mode  = mode_q;
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dqm,
  input logic       rd_hiz,
  input logic       err,
  input logic [3:0] bank_open,
  input logic [2:0] dev_mode
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;

  a_r10_read_mask_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (rd_hiz == $past(dqm, 2)));

  a_r2_no_open_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ((bank_open & ~$past(bank_open)) == 4'd0));

  a_r11_deep_exit_to_init: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dev_mode) == 3'd3) |-> (dev_mode == 3'd3 || dev_mode == 3'd4));

  a_r7_self_refresh_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dev_mode) == 3'd0 && dev_mode == 3'd2) |-> ($past(bank_open) == 4'd0));

  a_r12_init_keeps_closed: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dev_mode) == 3'd4) |-> (bank_open == 4'd0));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dqm(dqm), .rd_hiz(rd_hiz),
  .err(err), .bank_open(bank_open), .dev_mode(dev_mode)
);

// File: tb/sdram_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] bs = 2'd0, bl_sel = 2'd0;
  logic a10 = 1'b0, dqm = 1'b0;
  logic wr_mask, rd_hiz, err;
  logic [3:0] err_code, bank_open;
  logic [2:0] dev_mode;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bs(bs), .a10(a10), .bl_sel(bl_sel), .dqm(dqm), .wr_mask(wr_mask),
    .rd_hiz(rd_hiz), .err(err), .err_code(err_code), .bank_open(bank_open), .dev_mode(dev_mode)
  );

  localparam int MRS = 0, REF = 1, PRE = 2, ACT = 3, WR = 4, RD = 5, BST = 6, NOP = 7, DES = 8;

  int n_run = 0, n_fail = 0;
  bit [3:0] m_open;
  int m_lock [4];
  int m_bl, m_gap, m_mode, exp_code;
  bit m_ckeq, h1, h2;

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string code_tag(input int e);
    case (e)
      1: return "R2 reopen";
      2: return "R3 idle access";
      3: return "R5 mode set open";
      4: return "R7 refresh open";
      5: return "R6 mode gap";
      6: return "R8 lock";
      7: return "R12 init";
      default: return "R13 no error";
    endcase
  endfunction

  task automatic model_reset();
    m_open = 0; m_bl = 1; m_gap = 0; m_mode = 0; m_ckeq = 1; h1 = 0; h2 = 0;
    foreach (m_lock[i]) m_lock[i] = 0;
  endtask

  task automatic model_step(input int c);
    bit live, ent, lv, run, anyo, so, sl, rw, go, dpd;
    live = m_ckeq && cke; ent = m_ckeq && !cke; lv = !m_ckeq && cke;
    run  = live && (m_mode == 0 || m_mode == 4);
    anyo = m_open != 0; so = m_open[bs]; sl = m_lock[bs] != 0;
    rw = (c == WR || c == RD);
    exp_code = 0;
    if (run) begin
      if (m_mode == 4 && (c == ACT || rw || c == BST)) exp_code = 7;
      else if (m_gap != 0 && !(c == NOP || c == DES))  exp_code = 5;
      else if (c == ACT && so)                          exp_code = 1;
      else if (rw && !so)                               exp_code = 2;
      else if (rw && sl)                                exp_code = 6;
      else if (c == MRS && anyo)                        exp_code = 3;
      else if (c == REF && anyo)                        exp_code = 4;
    end else if (ent && m_mode == 0 && c == REF && anyo) exp_code = 4;
    go  = run && exp_code == 0;
    dpd = ent && m_mode == 0 && c == BST;
    for (int i = 0; i < 4; i++) begin
      if (dpd || (go && c == PRE && (a10 || bs == i))) begin m_open[i] = 0; m_lock[i] = 0; end
      else if (go && c == ACT && bs == i) m_open[i] = 1;
      else if (go && rw && a10 && bs == i) m_lock[i] = m_bl;
      else if (m_lock[i] == 1) begin m_open[i] = 0; m_lock[i] = 0; end
      else if (m_lock[i] != 0) m_lock[i]--;
    end
    if (go && c == MRS) m_gap = 2; else if (m_gap != 0) m_gap--;
    case (m_mode)
      0: if (ent) m_mode = (c == REF) ? (anyo ? 0 : 2) : (c == BST) ? 3 : 1;
      1, 2: if (lv) m_mode = 0;
      3: if (lv) m_mode = 4;
      4: if (go && c == MRS && !bs[1]) m_mode = 0;
      default: ;
    endcase
    if (go && c == MRS && !bs[1]) m_bl = 1 << bl_sel;
    m_ckeq = cke; h2 = h1; h1 = dqm;
  endtask

  task automatic issue(input int c, input int b = 0, input bit a = 0, input int op = 0,
                       input bit d = 0, input bit ck = 1);
    @(negedge clk);
    cke = ck; bs = 2'(b); a10 = a; bl_sel = 2'(op); dqm = d;
    if (c == DES) begin cs_n = 1; {ras_n, cas_n, we_n} = 3'b111; end
    else begin cs_n = 0; {ras_n, cas_n, we_n} = 3'(c); end
    #1 chk(int'(wr_mask), int'(d), "R9 write mask");
    model_step(c);
    @(posedge clk); #1;
    chk(int'(err_code), exp_code, code_tag(exp_code));
    chk(int'(err), int'(exp_code != 0), "R13 err pulse");
    chk(int'(bank_open), int'(m_open), "R1 R4 R8 bank state");
    chk(int'(dev_mode), m_mode, "R7 R11 R12 mode");
    chk(int'(rd_hiz), int'(h2), "R10 read mask");
  endtask

  initial begin
    #950us;
    n_fail++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(int'(err), 0, "R13 reset err");
    chk(int'(bank_open), 0, "R13 reset banks");
    chk(int'(dev_mode), 0, "R13 reset mode");

    issue(ACT, 2);              chk(int'(bank_open), 4, "R1 activate bank 2");
    issue(ACT, 2);              chk(int'(err_code), 1, "R2 reopen code");
                                chk(int'(bank_open), 4, "R2 state kept");
    issue(RD, 0);               chk(int'(err_code), 2, "R3 idle read");
    issue(ACT, 0);
    issue(PRE, 0, 0);           chk(int'(bank_open), 4, "R4 single close");
    issue(PRE, 1, 1);           chk(int'(bank_open), 0, "R4 all close");
    issue(MRS, 0, 0, 3);
    issue(ACT, 1);              chk(int'(err_code), 5, "R6 gap violation");
    issue(NOP);
    issue(ACT, 1);              chk(int'(bank_open), 2, "R6 gap over");
    issue(RD, 1, 1);
    issue(RD, 1);               chk(int'(err_code), 6, "R8 locked read");
    repeat (6) issue(NOP);      chk(int'(bank_open), 2, "R8 still locked");
    issue(NOP);                 chk(int'(bank_open), 0, "R8 auto close");
    issue(ACT, 3);
    issue(MRS);                 chk(int'(err_code), 3, "R5 mode set open");
    issue(REF);                 chk(int'(err_code), 4, "R7 refresh open");
    issue(REF, 0, 0, 0, 0, 0);  chk(int'(dev_mode), 0, "R7 self refresh refused");
    issue(NOP);
    issue(PRE, 0, 1);
    issue(REF, 0, 0, 0, 0, 0);  chk(int'(dev_mode), 2, "R7 self refresh entry");
    issue(NOP, 0, 0, 0, 0, 0);
    issue(NOP);                 chk(int'(dev_mode), 0, "R7 self refresh exit");
    issue(BST, 0, 0, 0, 0, 0);  chk(int'(dev_mode), 3, "R11 deep entry");
    issue(NOP, 0, 0, 0, 0, 0);
    issue(NOP);                 chk(int'(dev_mode), 4, "R11 deep exit");
    issue(ACT, 0);              chk(int'(err_code), 7, "R12 init block");
    issue(MRS, 2);              chk(int'(dev_mode), 4, "R12 extended keeps init");
    issue(NOP); issue(NOP);
    issue(MRS, 0, 0, 1);        chk(int'(dev_mode), 0, "R12 reinit");
    issue(NOP); issue(NOP);
    issue(NOP, 0, 0, 0, 0, 0);  chk(int'(dev_mode), 1, "R13 power down");
    issue(NOP);                 chk(int'(dev_mode), 0, "R13 power up");
    issue(NOP, 0, 0, 0, 1);     chk(int'(rd_hiz), 0, "R10 not yet");
    issue(NOP);                 chk(int'(rd_hiz), 1, "R10 two edges");
    issue(NOP);                 chk(int'(rd_hiz), 0, "R10 one cycle");

    for (int k = 0; k < 4000; k++) begin
      int r, c;
      bit ck;
      r = int'($urandom % 100);
      c = r < 8 ? MRS : r < 14 ? REF : r < 30 ? PRE : r < 50 ? ACT : r < 62 ? RD :
          r < 74 ? WR : r < 78 ? BST : r < 90 ? NOP : DES;
      ck = m_ckeq ? ($urandom % 40 != 0) : ($urandom % 3 == 0);
      issue(c, int'($urandom % 4), ($urandom % 3 == 0), int'($urandom % 4), $urandom % 2 == 1, ck);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule